// File: doc/BRIEF.md
# Watchdog Countdown Timer

This block is a watchdog counter with a 32-bit word register port. Software programs a reload value, turns the counter on through a control register, and must keep writing a 16-bit key to a restart register. Each key write puts the reload value back into the counter. If software stops writing the key, the counter runs down to zero and the block raises a single-cycle reset request for a separate pulse-shaping block.

The countdown advances once per tick. The tick is either every clock cycle or an external 1 MHz strobe, chosen by a control bit. A side input reports that the memory controller is itself held in reset. When that input is high at expiry, the watchdog does not request a reset. It clears its own control register, which turns it off.

The register port takes one access per cycle. Read data is registered and appears the cycle after the address is presented.

Top module: `wdog_timer`

## Requirements
- R1: After a synchronous reset, the count (byte offset 0x00) and the reload value (0x04) both read 0x03EF1480. Control (0x0C) and the mask register (0x1C) read 0, the pulse-width register (0x18) reads 0xFF, and `rst_req` is low.
- R2: The reload (0x04), pulse-width (0x18) and mask (0x1C) registers read back the last full word written to them. Control (0x0C) keeps only bits 5:0, and its upper bits read 0. Read data appears on `bus_rdata` one clock after the address is presented.
- R3: A write to 0x08 whose low 16 bits are 0x4755 copies the reload value into the count and arms the countdown, whatever the upper bits hold. A write of any other value leaves the count unchanged. Reading 0x08 returns 0.
- R4: The count register at 0x00 is read-only, and writes to it leave the count unchanged.
- R5: Offsets 0x10 and 0x14 and any unmapped offset read 0, and writes to them have no effect.
- R6: The control bits are: bit 0 enable, bit 1 system-reset action, bit 2 interrupt enable, bit 3 external-signal enable, bit 4 tick select, bit 5 full-chip reset mode. With bit 4 at 1, the enabled count falls by one in each cycle where `tick_1mhz` is high. With bit 4 at 0, it falls by one every cycle.
- R7: A control write that changes the enable bit from 0 to 1 loads the count from the reload value. A write that clears the enable bit freezes the count. A write that leaves the enable bit unchanged only updates the control register.
- R8: At a tick where the count is 1, the count becomes 0 and `rst_req` is high for exactly that one following cycle. Counting then stops with the enable bit still set, until a key write or a fresh enable.
- R9: If `mem_ctl_in_reset` is high at expiry, the control register becomes 0 and `rst_req` stays low.
- R10: A count of 0 never decrements or wraps, so an armed counter loaded with 0 never requests a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Byte address of the word access; the low two bits are ignored |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data for the address of the previous cycle |
| tick_1mhz | input | 1 | 1 MHz strobe used as the tick when control bit 4 is set |
| mem_ctl_in_reset | input | 1 | Memory controller held in reset; suppresses the reset request |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The embedded assertions check several rules on every cycle:
- a reset request lasts one cycle and coincides with a zero count;
- a key write or enable edge lands the reload value in the count;
- the count only holds or steps down by one, and never leaves zero on its own;
- an expiry with the memory-reset flag high clears control and gives no request.

Other rules are shown only by the bench's scenarios:
- the exact expiry cycle after a reload;
- which key values are rejected;
- read-back masking of control;
- inert reserved offsets;
- that clearing the enable bit freezes the count rather than reloading it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // byte offsets of the word registers
  localparam int unsigned OFF_COUNT  = 32'h00;
  localparam int unsigned OFF_RELOAD = 32'h04;
  localparam int unsigned OFF_KICK   = 32'h08;
  localparam int unsigned OFF_CTRL   = 32'h0C;
  localparam int unsigned OFF_WIDTH  = 32'h18;
  localparam int unsigned OFF_MASK   = 32'h1C;

  localparam logic [15:0] KICK_KEY   = 16'h4755;
  localparam int unsigned CTRL_BITS  = 6;

  localparam logic [31:0] RST_COUNT_VAL = 32'h03EF1480;
  localparam logic [31:0] RST_WIDTH_VAL = 32'h0000_00FF;

  // control word, bit 0 at the bottom
  typedef struct packed {
    logic full_chip;
    logic slow_tick;
    logic ext_sig;
    logic irq_en;
    logic sys_rst;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] cnt_val,
  input  logic              expire,
  input  logic              mem_rst,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] reload,
  output logic              kick,
  output logic              en_rise
);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFF_RELOAD);
  localparam logic [ADDR_W-1:0] A_KICK   = ADDR_W'(OFF_KICK);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_WIDTH  = ADDR_W'(OFF_WIDTH);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);
  localparam int unsigned       PAD_W    = DATA_W - CTRL_BITS;

  logic [ADDR_W-1:0] wa;
  logic [DATA_W-1:0] width_q, mask_q, rd_mux;
  logic              wr_ctrl;

  assign wa      = {bus_addr[ADDR_W-1:2], 2'b00};
  assign wr_ctrl = bus_we && (wa == A_CTRL);
  assign kick    = bus_we && (wa == A_KICK) && (bus_wdata[15:0] == KICK_KEY);
  assign en_rise = wr_ctrl && bus_wdata[0] && !ctrl.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      reload  <= DATA_W'(RST_COUNT_VAL);
      width_q <= DATA_W'(RST_WIDTH_VAL);
      mask_q  <= '0;
    end else begin
      if (expire && mem_rst)
        ctrl <= '0;
      else if (wr_ctrl)
        ctrl <= ctrl_t'(bus_wdata[CTRL_BITS-1:0]);
      if (bus_we && wa == A_RELOAD) reload  <= bus_wdata;
      if (bus_we && wa == A_WIDTH)  width_q <= bus_wdata;
      if (bus_we && wa == A_MASK)   mask_q  <= bus_wdata;
    end
  end

  always_comb begin
    case (wa)
      A_COUNT:  rd_mux = cnt_val;
      A_RELOAD: rd_mux = reload;
      A_CTRL:   rd_mux = {{PAD_W{1'b0}}, ctrl};
      A_WIDTH:  rd_mux = width_q;
      A_MASK:   rd_mux = mask_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  AST_MEMRST_CLEARS_CTRL: assert property (@(posedge clk) disable iff (rst)
    (expire && mem_rst) |=> (ctrl == '0)); // R9
  AST_KICK_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wa == A_KICK) |=> (bus_rdata == '0)); // R3
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned DATA_W  = 32,
  parameter logic [DATA_W-1:0] RST_VAL = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_en,
  input  logic              slow_sel,
  input  logic              tick_1mhz,
  input  logic              mem_rst,
  input  logic              load,
  input  logic [DATA_W-1:0] reload,
  output logic [DATA_W-1:0] count,
  output logic              expire,
  output logic              rst_req
);
  logic armed, tick, step;

  assign tick   = slow_sel ? tick_1mhz : 1'b1;
  assign step   = !load && ctrl_en && armed && tick && (count != '0);
  assign expire = step && (count == DATA_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= RST_VAL;
      armed   <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (load) begin
        count <= reload;
        armed <= 1'b1;
      end else if (step) begin
        count <= count - DATA_W'(1);
        if (expire) begin
          armed   <= 1'b0;
          rst_req <= !mem_rst;
        end
      end
    end
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req); // R8
  AST_REQ_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (count == '0)); // R8
  AST_LOAD_TAKES_RELOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == $past(reload))); // R3
  AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ((count == '0) && !load) |=> (count == '0)); // R10
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (!load && count != '0) |=> (count == $past(count) || count == $past(count) - DATA_W'(1))); // R6
  AST_MEMRST_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (expire && mem_rst) |=> !rst_req); // R9
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_1mhz,
  input  logic              mem_ctl_in_reset,
  output logic              rst_req
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] reload, count;
  logic              kick, en_rise, expire;

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt_val   (count),
    .expire    (expire),
    .mem_rst   (mem_ctl_in_reset),
    .ctrl      (ctrl),
    .reload    (reload),
    .kick      (kick),
    .en_rise   (en_rise)
  );

  wdog_counter #(.DATA_W(DATA_W), .RST_VAL(DATA_W'(RST_COUNT_VAL))) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .ctrl_en   (ctrl.en),
    .slow_sel  (ctrl.slow_tick),
    .tick_1mhz (tick_1mhz),
    .mem_rst   (mem_ctl_in_reset),
    .load      (kick || en_rise),
    .reload    (reload),
    .count     (count),
    .expire    (expire),
    .rst_req   (rst_req)
  );
endmodule

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_1mhz = 1'b0;
  logic        mem_ctl_in_reset = 1'b0;
  logic        rst_req;
  int          tests = 0;
  int          fails = 0;
  logic [31:0] got;

  always #5 clk = ~clk;

  wdog_timer i_wdog_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_1mhz(tick_1mhz),
    .mem_ctl_in_reset(mem_ctl_in_reset), .rst_req(rst_req)
  );

  // {write, requirement number, byte address, write data, expected read}
  localparam int NV = 34;
  localparam logic [80:0] VEC [NV] = '{
    {1'b0, 8'd1, 8'h00, 32'h0,        32'h03EF1480}, // R1 count
    {1'b0, 8'd1, 8'h04, 32'h0,        32'h03EF1480}, // R1 reload
    {1'b0, 8'd1, 8'h0C, 32'h0,        32'h0},        // R1 control
    {1'b0, 8'd1, 8'h18, 32'h0,        32'hFF},       // R1 width
    {1'b0, 8'd1, 8'h1C, 32'h0,        32'h0},        // R1 mask
    {1'b1, 8'd2, 8'h04, 32'h100,      32'h0},        // R2
    {1'b0, 8'd2, 8'h04, 32'h0,        32'h100},      // R2
    {1'b1, 8'd4, 8'h00, 32'h1234,     32'h0},        // R4
    {1'b0, 8'd4, 8'h00, 32'h0,        32'h03EF1480}, // R4
    {1'b1, 8'd3, 8'h08, 32'hAAAA4756, 32'h0},        // R3 wrong key
    {1'b0, 8'd3, 8'h00, 32'h0,        32'h03EF1480}, // R3
    {1'b1, 8'd3, 8'h08, 32'hFFFF4755, 32'h0},        // R3 key, junk above
    {1'b0, 8'd3, 8'h00, 32'h0,        32'h100},      // R3
    {1'b0, 8'd3, 8'h08, 32'h0,        32'h0},        // R3 reads 0
    {1'b1, 8'd5, 8'h10, 32'h5,        32'h0},        // R5
    {1'b0, 8'd5, 8'h10, 32'h0,        32'h0},        // R5
    {1'b1, 8'd5, 8'h14, 32'h7,        32'h0},        // R5
    {1'b0, 8'd5, 8'h14, 32'h0,        32'h0},        // R5
    {1'b1, 8'd5, 8'h24, 32'h9,        32'h0},        // R5 unmapped
    {1'b0, 8'd5, 8'h24, 32'h0,        32'h0},        // R5
    {1'b1, 8'd2, 8'h0C, 32'hFFFFFF3E, 32'h0},        // R2 control mask
    {1'b0, 8'd2, 8'h0C, 32'h0,        32'h3E},       // R2
    {1'b1, 8'd2, 8'h1C, 32'hDEADBEEF, 32'h0},        // R2
    {1'b0, 8'd2, 8'h1C, 32'h0,        32'hDEADBEEF}, // R2
    {1'b1, 8'd2, 8'h18, 32'h12345678, 32'h0},        // R2
    {1'b0, 8'd2, 8'h18, 32'h0,        32'h12345678}, // R2
    {1'b1, 8'd7, 8'h0C, 32'h10,       32'h0},        // R7 off, slow tick
    {1'b1, 8'd7, 8'h04, 32'h40,       32'h0},        // R7
    {1'b1, 8'd7, 8'h0C, 32'h11,       32'h0},        // R7 rising enable
    {1'b0, 8'd7, 8'h00, 32'h0,        32'h40},       // R7 reloaded
    {1'b1, 8'd7, 8'h04, 32'h7,        32'h0},        // R7
    {1'b1, 8'd7, 8'h0C, 32'h13,       32'h0},        // R7 enable unchanged
    {1'b0, 8'd7, 8'h00, 32'h0,        32'h40},       // R7 no reload
    {1'b0, 8'd6, 8'h0C, 32'h0,        32'h13}        // R6 bits kept
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk);
    #1 d = bus_rdata;
  endtask

  task automatic tick_pulse();
    @(negedge clk);
    tick_1mhz = 1'b1;
    @(posedge clk);
    #1 tick_1mhz = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1 rst_req", {31'b0, rst_req}, 32'h0);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][80]) wr(VEC[i][71:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][71:64], got);
        chk($sformatf("R%0d vec %0d", VEC[i][79:72], i), got, VEC[i][31:0]);
      end
    end

    // R8: per-cycle countdown from 5, request at the fifth edge
    wr(8'h0C, 32'h0);
    wr(8'h04, 32'h5);
    wr(8'h0C, 32'h3);
    repeat (4) @(posedge clk);
    #1 chk("R8 early", {31'b0, rst_req}, 32'h0);
    @(posedge clk);
    #1 chk("R8 fire", {31'b0, rst_req}, 32'h1);
    @(posedge clk);
    #1 chk("R8 one cycle", {31'b0, rst_req}, 32'h0);
    repeat (5) @(posedge clk);
    #1 chk("R8 stopped", {31'b0, rst_req}, 32'h0);
    rd(8'h00, got); chk("R8 count zero", got, 32'h0);
    rd(8'h0C, got); chk("R8 enable kept", got, 32'h3);

    // R6: 1 MHz strobe drives the count
    wr(8'h0C, 32'h13);
    wr(8'h08, 32'h4755);
    repeat (4) @(posedge clk);
    rd(8'h00, got); chk("R6 no strobe holds", got, 32'h5);
    repeat (3) tick_pulse();
    rd(8'h00, got); chk("R6 three strobes", got, 32'h2);

    // R9: expiry while memory controller in reset
    @(negedge clk) mem_ctl_in_reset = 1'b1;
    tick_pulse();
    chk("R9 before", {31'b0, rst_req}, 32'h0);
    tick_pulse();
    chk("R9 no request", {31'b0, rst_req}, 32'h0);
    rd(8'h0C, got); chk("R9 control cleared", got, 32'h0);
    rd(8'h00, got); chk("R9 count zero", got, 32'h0);
    @(negedge clk) mem_ctl_in_reset = 1'b0;

    // R7: clearing enable freezes the count
    wr(8'h04, 32'd100);
    wr(8'h0C, 32'h3);
    wr(8'h0C, 32'h2);
    repeat (5) @(posedge clk);
    rd(8'h00, got); chk("R7 frozen", got, 32'd99);

    // R1: reset in the middle of operation
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    #1 chk("R1 rst_req after reset", {31'b0, rst_req}, 32'h0);
    @(negedge clk) rst = 1'b0;
    rd(8'h00, got); chk("R1 count again", got, 32'h03EF1480);
    rd(8'h0C, got); chk("R1 control again", got, 32'h0);
    rd(8'h1C, got); chk("R1 mask again", got, 32'h0);
    rd(8'h18, got); chk("R1 width again", got, 32'hFF);

    // R10: armed at zero never requests
    wr(8'h04, 32'h0);
    wr(8'h0C, 32'h1);
    got = 32'h0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk);
      #1 if (rst_req) got = 32'h1;
    end
    chk("R10 no request", got, 32'h0);
    rd(8'h00, got); chk("R10 count stays zero", got, 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule